// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a clocked system and an external asynchronous static RAM of 128K bytes. The RAM has two select inputs of opposite polarity, an active-low write strobe and an active-low output enable. The system hands over one request at a time: a read or a write with an address and write data, accepted in the cycle where `reqValid` and `reqReady` are both high. The controller then steps through a timed sequence of pin states that meets the RAM's minimum intervals. When a read completes, it returns the captured byte on a one-cycle response pulse.

Each timing rule of the RAM has its own parameter in nanoseconds. The controller turns each one into a whole number of cycles with `cyc(ns) = max(1, ceil(ns / CLK_PERIOD_NS))`. From these it builds separate counts for address setup, write-pulse length, data-bus turn-on delay inside the pulse, read access and bus turnaround. It does not use one shared wait count. The data bus is split into an output, an input and an output-enable, which the pad ring joins into the bidirectional pins.

With the defaults (10 ns clock) the counts are as follows:
- setup: 1 cycle
- write pulse: 2 cycles, with the bus driven from the second
- hold: 1 cycle
- read access: 2 cycles
- turnaround: 1 cycle

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it:
  - `reqReady` is high and `rspValid` is low.
  - The RAM is deselected (`memSelN`=1, `memSelP`=0).
  - `memWrN`=1, `memOeN`=1 and `memDqOe`=0.
- R2: The RAM is selected only with both selects active together (`memSelN`=0 and `memSelP`=1). `memWrN` is never low unless the RAM is selected.
- R3: A write selects the RAM with the request address for setupCyc = cyc(T_AS) cycles before `memWrN` falls. `memWrN` then stays low for pulseCyc = max(cyc(T_PWE), cyc(T_AW), cyc(T_HZWE)+cyc(T_SD), cyc(T_WC)-setupCyc-1) cycles. The address is stable the whole time and meets the write-pulse, address-to-write-end and cycle-time minimums.
- R4: During a write, `memDqOut` carries the request data. `memDqOe` rises only after `memWrN` has been low for cyc(T_HZWE) cycles, and stays high for exactly one hold cycle after `memWrN` returns high. The data is stable while driven and is set up at least T_SD before write end.
- R5: `memOeN` stays high for the whole of every write. `memDqOe` is never high while `memOeN` is low, nor within T_HZOE after `memOeN` rises.
- R6: A read holds the RAM selected with `memOeN`=0 and `memWrN`=1 for rdCyc = max(cyc(T_RC), cyc(T_AA), cyc(T_DOE)) cycles. `rspRdata` then returns the byte last written to that address. Addresses never written read as 0 in the bench memory.
- R7: `rspValid` is high for exactly one cycle. It is sampled high rdCyc+1 falling clock edges after the edge that accepts the read.
- R8: `reqReady` is low from the accepting edge until the sequence ends. A write keeps it low for setupCyc+pulseCyc+1+turnCyc cycles. A request held valid meanwhile is neither dropped nor duplicated; it is taken when `reqReady` returns.
- R9: After every transfer the RAM is deselected and the bus released for turnCyc = cyc(max(T_HZOE, T_LZWE)) cycles before the next transfer selects it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | DATA_W | Write data |
| reqReady | output | 1 | Controller idle, request accepted this cycle if valid |
| rspValid | output | 1 | One-cycle read data strobe |
| rspRdata | output | DATA_W | Captured read data |
| memAddr | output | ADDR_W | RAM address pins |
| memSelN | output | 1 | Active-low RAM select |
| memSelP | output | 1 | Active-high RAM select |
| memWrN | output | 1 | Active-low write strobe |
| memOeN | output | 1 | Active-low RAM output enable |
| memDqOut | output | DATA_W | Data toward the RAM |
| memDqOe | output | 1 | Drive enable for the data pins |
| memDqIn | input | DATA_W | Data from the RAM pins |

## Verification
The hardest case to reach from the ports is a read accepted right after a write, or a write right after a read, with the request already waiting while the controller is busy. Only then do the turnaround window and the bus handover between RAM and controller meet. The bench keeps `reqValid` high across busy periods and mixes reads and writes at random, so back-to-back direction changes occur many times. A behavioural memory model checks every write against the nanosecond minimums, returns corrupted data when a read is sampled before access time, and flags any overlap of both drivers on the bus.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_READ,
    ST_TURN
  } ctrl_state_t;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic load;     // capture request address/data
    logic sel;      // RAM selected
    logic wr;       // write strobe active
    logic oe;       // RAM output enable active
    logic drive;    // controller drives data pins
    logic capture;  // sample read data this cycle
  } strobe_t;

  // Whole cycles covering a time in ns, never less than one
  function automatic int nsToCyc(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_AS_NS   = 0,
  parameter int T_PWE_NS  = 10,
  parameter int T_AW_NS   = 10,
  parameter int T_SD_NS   = 7,
  parameter int T_WC_NS   = 12,
  parameter int T_HZWE_NS = 7,
  parameter int T_LZWE_NS = 2,
  parameter int T_RC_NS   = 12,
  parameter int T_AA_NS   = 12,
  parameter int T_DOE_NS  = 6,
  parameter int T_HZOE_NS = 6
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t stb
);

  localparam int SETUP_CYC = nsToCyc(T_AS_NS, CLK_PERIOD_NS);
  localparam int HZ_CYC    = nsToCyc(T_HZWE_NS, CLK_PERIOD_NS);
  localparam int SD_CYC    = nsToCyc(T_SD_NS, CLK_PERIOD_NS);
  localparam int PWE_CYC   = nsToCyc(T_PWE_NS, CLK_PERIOD_NS);
  localparam int AW_CYC    = nsToCyc(T_AW_NS, CLK_PERIOD_NS);
  localparam int WC_CYC    = nsToCyc(T_WC_NS, CLK_PERIOD_NS);
  localparam int PULSE_CYC = maxOf(maxOf(PWE_CYC, AW_CYC),
                                   maxOf(HZ_CYC + SD_CYC, WC_CYC - SETUP_CYC - 1));
  localparam int RD_CYC    = maxOf(nsToCyc(T_RC_NS, CLK_PERIOD_NS),
                                   maxOf(nsToCyc(T_AA_NS, CLK_PERIOD_NS),
                                         nsToCyc(T_DOE_NS, CLK_PERIOD_NS)));
  localparam int TURN_CYC  = nsToCyc(maxOf(T_HZOE_NS, T_LZWE_NS), CLK_PERIOD_NS);
  localparam int MAX_CYC   = maxOf(maxOf(SETUP_CYC, PULSE_CYC), maxOf(RD_CYC, TURN_CYC));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  ctrl_state_t state, nextState;
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] lastIdx;
  logic             lastCyc;

  // Length of the current phase, one count per timing rule
  always_comb begin
    unique case (state)
      ST_WSETUP: lastIdx = CNT_W'(SETUP_CYC - 1);
      ST_WPULSE: lastIdx = CNT_W'(PULSE_CYC - 1);
      ST_READ:   lastIdx = CNT_W'(RD_CYC - 1);
      ST_TURN:   lastIdx = CNT_W'(TURN_CYC - 1);
      default:   lastIdx = '0;
    endcase
  end

  assign lastCyc = (phaseCnt == lastIdx);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:   if (reqValid) nextState = reqWrite ? ST_WSETUP : ST_READ;
      ST_WSETUP: if (lastCyc) nextState = ST_WPULSE;
      ST_WPULSE: if (lastCyc) nextState = ST_WHOLD;
      ST_WHOLD:  nextState = ST_TURN;
      ST_READ:   if (lastCyc) nextState = ST_TURN;
      ST_TURN:   if (lastCyc) nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
    end else begin
      state    <= nextState;
      phaseCnt <= (nextState != state || state == ST_IDLE) ? '0 : phaseCnt + 1'b1;
    end
  end

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    stb.load    = (state == ST_IDLE) && reqValid;
    stb.sel     = (state == ST_WSETUP) || (state == ST_WPULSE) ||
                  (state == ST_WHOLD)  || (state == ST_READ);
    stb.wr      = (state == ST_WPULSE);
    stb.oe      = (state == ST_READ);
    stb.drive   = ((state == ST_WPULSE) && (phaseCnt >= CNT_W'(HZ_CYC))) ||
                  (state == ST_WHOLD);
    stb.capture = (state == ST_READ) && lastCyc;
  end

  AST_NO_LOAD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |-> !stb.load); // R8
  AST_CAPTURE_THEN_TURN: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> (state == ST_TURN && !stb.sel)); // R9
  AST_HOLD_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stb.wr) |-> (stb.drive && stb.sel)); // R4

endmodule

// File: rtl/sram_ctrl_dpath.sv
`timescale 1ns/1ps
module sram_ctrl_dpath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memSelN,
  output logic              memSelP,
  output logic              memWrN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdataReg;
  logic              rspReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
    end else if (stb.load) begin
      addrReg  <= reqAddr;
      wdataReg <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataReg <= '0;
      rspReg   <= 1'b0;
    end else begin
      rspReg <= stb.capture;
      if (stb.capture) rdataReg <= memDqIn;
    end
  end

  assign memAddr  = addrReg;
  assign memDqOut = wdataReg;
  assign memDqOe  = stb.drive;
  assign memSelN  = ~stb.sel;
  assign memSelP  = stb.sel;
  assign memWrN   = ~stb.wr;
  assign memOeN   = ~stb.oe;
  assign rspValid = rspReg;
  assign rspRdata = rdataReg;

  AST_WRITE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    !memWrN |-> (!memSelN && memSelP)); // R2
  AST_NO_DRIVE_WITH_OE: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN); // R5
  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !memWrN |-> memOeN); // R5
  AST_ADDR_STABLE_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!memWrN && !$past(memWrN)) |-> $stable(memAddr)); // R3
  AST_DATA_STABLE_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    (memDqOe && $past(memDqOe)) |-> $stable(memDqOut)); // R4
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R7

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int T_AS_NS   = 0,
  parameter int T_PWE_NS  = 10,
  parameter int T_AW_NS   = 10,
  parameter int T_SD_NS   = 7,
  parameter int T_WC_NS   = 12,
  parameter int T_HZWE_NS = 7,
  parameter int T_LZWE_NS = 2,
  parameter int T_RC_NS   = 12,
  parameter int T_AA_NS   = 12,
  parameter int T_DOE_NS  = 6,
  parameter int T_HZOE_NS = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memSelN,
  output logic              memSelP,
  output logic              memWrN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  strobe_t stb;

  sram_ctrl_fsm #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .T_AS_NS(T_AS_NS), .T_PWE_NS(T_PWE_NS), .T_AW_NS(T_AW_NS),
    .T_SD_NS(T_SD_NS), .T_WC_NS(T_WC_NS), .T_HZWE_NS(T_HZWE_NS),
    .T_LZWE_NS(T_LZWE_NS), .T_RC_NS(T_RC_NS), .T_AA_NS(T_AA_NS),
    .T_DOE_NS(T_DOE_NS), .T_HZOE_NS(T_HZOE_NS)
  ) u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqReady (reqReady),
    .stb      (stb)
  );

  sram_ctrl_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .rspValid (rspValid),
    .rspRdata (rspRdata),
    .memAddr  (memAddr),
    .memSelN  (memSelN),
    .memSelP  (memSelP),
    .memWrN   (memWrN),
    .memOeN   (memOeN),
    .memDqOut (memDqOut),
    .memDqOe  (memDqOe),
    .memDqIn  (memDqIn)
  );

  AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memSelN && !memSelP && !memDqOe)); // R9
  AST_SELECTS_PAIRED: assert property (@(posedge clk) disable iff (!rstN)
    memSelN == !memSelP); // R2

endmodule

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb;

  localparam int P = 10;
  localparam int AW = 17;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN, reqValid, reqWrite, reqReady, rspValid;
  logic [AW-1:0] reqAddr, memAddr;
  logic [DW-1:0] reqWdata, rspRdata, memDqOut, memDqIn;
  logic          memSelN, memSelP, memWrN, memOeN, memDqOe;

  sram_async_ctrl u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspValid(rspValid), .rspRdata(rspRdata), .memAddr(memAddr),
    .memSelN(memSelN), .memSelP(memSelP), .memWrN(memWrN), .memOeN(memOeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int cyc(input int ns);
    int c;
    c = (ns + P - 1) / P;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  function automatic int expSetup(); return cyc(0); endfunction
  function automatic int expHz(); return cyc(7); endfunction
  function automatic int expPulse();
    return mx(mx(cyc(10), cyc(10)), mx(cyc(7) + cyc(7), cyc(12) - expSetup() - 1));
  endfunction
  function automatic int expRd(); return mx(cyc(12), mx(cyc(12), cyc(6))); endfunction
  function automatic int expTurn(); return cyc(mx(6, 2)); endfunction

  // ---------------- behavioural RAM with timing checks ----------------
  logic [DW-1:0] ram [int];
  logic [DW-1:0] shadow [int];
  realtime tAddr = 0, tWrFall = 0, tOeFall = 0, tOeRise = -100, tSel = 0, tDq = 0;
  int timingErr = 0, contentionErr = 0;
  wire selected = !memSelN && memSelP;

  function automatic logic [DW-1:0] ramRd(input int a);
    return ram.exists(a) ? ram[a] : '0;
  endfunction

  always @(memAddr) tAddr = $realtime;
  always @(negedge memWrN) tWrFall = $realtime;
  always @(negedge memOeN) tOeFall = $realtime;
  always @(posedge memOeN) tOeRise = $realtime;
  always @(posedge memSelP) tSel = $realtime;
  always @(memDqOut or memDqOe) tDq = $realtime;

  always @(posedge memWrN) begin
    if (selected) begin
      if ($realtime - tWrFall < 10.0) timingErr++;
      if ($realtime - tAddr < 10.0) timingErr++;
      if ($realtime - tSel < 12.0) timingErr++;
      if (!memDqOe || ($realtime - tDq < 7.0)) timingErr++;
      ram[int'(memAddr)] = memDqOut;
    end
  end

  always @(posedge memDqOe) if ($realtime - tOeRise < 6.0) contentionErr++;

  initial begin
    memDqIn = '0;
    #0.5;
    forever begin
      if (selected && !memOeN && memWrN && ($realtime - tAddr >= 12.0) &&
          ($realtime - tOeFall >= 6.0) && ($realtime - tSel >= 12.0))
        memDqIn = ramRd(int'(memAddr));
      else
        memDqIn = ~ramRd(int'(memAddr));
      #1;
    end
  end

  // ---------------- cycle monitors ----------------
  int wrLowCnt = 0, drvLowCnt = 0, drvHighCnt = 0, readyLowCnt = 0;
  int oeBad = 0, wrUnsel = 0, deselRun = 0, minGap = 1000;
  logic [AW-1:0] wrAddrSeen;
  logic [DW-1:0] wrDataSeen;
  bit prevSel = 0, seenSel = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (!memWrN) begin
        wrLowCnt++;
        wrAddrSeen = memAddr;
      end
      if (!memWrN && memDqOe) begin
        drvLowCnt++;
        wrDataSeen = memDqOut;
      end
      if (memWrN && memDqOe) drvHighCnt++;
      if (!reqReady) readyLowCnt++;
      if (memDqOe && !memOeN) oeBad++;
      if (!memWrN && !memOeN) oeBad++;
      if (memDqOe && selected && !memOeN && memWrN) contentionErr++;
      if (!memWrN && !selected) wrUnsel++;
      if (selected && !prevSel) begin
        if (seenSel && deselRun < minGap) minGap = deselRun;
        seenSel = 1;
      end
      deselRun = selected ? 0 : deselRun + 1;
      prevSel = selected;
    end
  end

  task automatic clearCounts();
    wrLowCnt = 0; drvLowCnt = 0; drvHighCnt = 0; readyLowCnt = 0;
  endtask

  // ---------------- drivers ----------------
  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 0;
    shadow[int'(a)] = d;
  endtask

  task automatic doRead(input logic [AW-1:0] a, output logic [DW-1:0] d,
                        output int lat, output bit oneCyc);
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAddr = a; reqWdata = '0;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 0;
    lat = 1;
    while (!rspValid) begin
      @(negedge clk);
      lat++;
    end
    d = rspRdata;
    @(negedge clk);
    oneCyc = !rspValid;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (!reqReady) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] expData(input logic [AW-1:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : '0;
  endfunction

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    logic [DW-1:0] rd;
    int lat;
    bit one;
    void'($urandom(32'd20240611));
    rstN = 0; reqValid = 0; reqWrite = 0; reqAddr = '0; reqWdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(reqReady && !rspValid, "R1", "ready/rsp at reset", {reqReady, rspValid}, 2);
    check(memSelN && !memSelP && memWrN && memOeN && !memDqOe, "R1", "pins at reset",
          {memSelN, memSelP, memWrN, memOeN, memDqOe}, 5'b10110);
    rstN = 1;
    @(negedge clk);
    check(reqReady && memSelN && !memSelP && !memDqOe, "R1", "idle after reset",
          {reqReady, memSelN, memSelP, memDqOe}, 4'b1100);

    // directed write at top address
    clearCounts();
    doWrite(17'h1FFFF, 8'hA5);
    waitIdle();
    check(wrLowCnt == expPulse(), "R3", "write pulse cycles", wrLowCnt, expPulse());
    check(wrAddrSeen == 17'h1FFFF, "R3", "address during pulse", int'(wrAddrSeen), 'h1FFFF);
    check(drvLowCnt == expPulse() - expHz(), "R4", "driven cycles in pulse",
          drvLowCnt, expPulse() - expHz());
    check(drvHighCnt == 1, "R4", "hold drive cycles", drvHighCnt, 1);
    check(wrDataSeen == 8'hA5, "R4", "driven data", int'(wrDataSeen), 'hA5);
    check(readyLowCnt == expSetup() + expPulse() + 1 + expTurn(), "R8", "busy cycles",
          readyLowCnt, expSetup() + expPulse() + 1 + expTurn());
    check(oeBad == 0, "R5", "output enable during write", oeBad, 0);
    check(wrUnsel == 0, "R2", "write strobe while deselected", wrUnsel, 0);

    // directed read back
    doRead(17'h1FFFF, rd, lat, one);
    check(rd == 8'hA5, "R6", "read back top address", int'(rd), 'hA5);
    check(lat == expRd() + 1, "R7", "read latency", lat, expRd() + 1);
    check(one, "R7", "response width one cycle", int'(one), 1);
    doRead(17'h00000, rd, lat, one);
    check(rd == 8'h00, "R6", "unwritten address", int'(rd), 0);

    // held-off request: read issued while write still busy
    doWrite(17'h00005, 8'h11);
    doRead(17'h00005, rd, lat, one);
    check(rd == 8'h11, "R8", "held read after write", int'(rd), 'h11);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = ($urandom_range(0, 1) == 1) ? AW'($urandom_range(0, 31)) : AW'($urandom);
      d = DW'($urandom);
      if ($urandom_range(0, 1) == 1) doWrite(a, d);
      else begin
        doRead(a, rd, lat, one);
        check(rd == expData(a), "R6", "random read data", int'(rd), int'(expData(a)));
      end
    end
    waitIdle();

    check(timingErr == 0, "R3", "memory model timing violations", timingErr, 0);
    check(contentionErr == 0, "R5", "bus contention events", contentionErr, 0);
    check(oeBad == 0, "R5", "output enable overlap", oeBad, 0);
    check(wrUnsel == 0, "R2", "write while deselected", wrUnsel, 0);
    check(minGap >= expTurn(), "R9", "deselect gap", minGap, expTurn());
    finishRun();
  end

endmodule